// File: doc/BRIEF.md
# Atomic Lock-Word Bank

This block sits next to the data memory of a processor with two cores or two hardware threads. It holds a small set of 32-bit lock words in a fixed address window at the top of the address space. Each of the two request ports carries loads and stores. A load that hits the window is an atomic test-and-set: it returns the word as it was and leaves the location at one. A store that hits the window writes its data, so software releases a lock by storing zero. Requests outside the window go straight to the memory interface of the same port.

Each port is a valid/ready request channel. The requester raises `req_valid_i` and holds the write flag, address and write data stable until `req_ready_o` is high at a clock edge. That edge is the handshake, and load data on `rsp_rdata_o` is valid in the same cycle. A window load always sees one stall cycle before its handshake. When both ports contend for one lock word, port 0 goes first. A port that touches a word which the other port's test-and-set currently holds is stalled until that operation completes. `stall_o` flags, per port, a request that is waiting.

Top module: `tas_sync_bank`

## Requirements
- R1: A request whose address is outside 0xFFFFFFE0..0xFFFFFFEF is forwarded unchanged on the memory interface of its port, with `mem_valid_o` high. Its ready and load data come from `mem_ready_i` and `mem_rdata_i` in the same cycle, with no added stall. 0xFFFFFFDF and 0xFFFFFFF0 lie outside the window.
- R2: An uncontended window load stalls for exactly one cycle and completes its handshake in its second cycle. An uncontended window store completes in its first cycle.
- R3: A window load returns the value the addressed location held before the load.
- R4: After a window load, the addressed location holds the value 1.
- R5: A window store writes its data into the addressed location. Storing zero releases the lock, so the next load returns 0.
- R6: When both ports request the same location in the same cycle, port 0 is served first. Port 1 stalls and then operates on the value port 0 left behind.
- R7: While one port's test-and-set on a location is in progress, any request from the other port to that location stalls until it completes. The location stays nonzero during that time.
- R8: After reset all 16 locations read as zero (unlocked), and no port signals a stall while idle.
- R9: The 16 locations are selected by address bits [3:0] and are independent. Requests from the two ports to different locations in the same cycle both proceed without extra stall.
- R10: `stall_o` of a port is high exactly when that port has a valid request that is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 2 | Request valid, one bit per port |
| req_ready_o | output | 2 | Request accepted at this edge, per port |
| req_write_i | input | 2 | 1 = store, 0 = load, per port |
| req_addr_i | input | 2x32 | Byte address per port |
| req_wdata_i | input | 2x32 | Store data per port |
| rsp_rdata_o | output | 2x32 | Load data, valid in the handshake cycle |
| stall_o | output | 2 | Request waiting, per port |
| mem_valid_o | output | 2 | Forwarded request valid, per port |
| mem_ready_i | input | 2 | Memory accepts the forwarded request |
| mem_write_o | output | 2 | Forwarded write flag |
| mem_addr_o | output | 2x32 | Forwarded address |
| mem_wdata_o | output | 2x32 | Forwarded store data |
| mem_rdata_i | input | 2x32 | Memory load data for the forwarded request |

## Verification
The bench targets same-cycle collisions on one lock word. A design with the wrong priority or no stall would hand port 1 the old zero as well, so both threads would believe they own the lock. It starts a request one cycle into the other port's test-and-set. A design that only arbitrates requests arriving together would let the late store or load slip through mid-operation. The addresses on each side of the window edge catch an off-by-one decode, which would either stall ordinary memory or leak lock traffic to it. A store of zero followed by a reload checks that release really clears the word rather than leaving it set.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HOLD = 1'b1
  } tas_phase_e;
endpackage

// File: rtl/tas_addr_decode.sv
module tas_addr_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_FFE0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  // The window spans 2**IDX_W bytes, aligned on its own size.
  assign hit_o = (addr_i[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/tas_port_ctrl.sv
module tas_port_ctrl
  import tas_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              grant_i,
  input  logic [DATA_W-1:0] lock_rd_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              want_o,
  output logic              hold_o,
  output logic [IDX_W-1:0]  hold_idx_o,
  output logic              we_o,
  output logic [DATA_W-1:0] we_data_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stall_o,
  output logic              mem_valid_o
);
  localparam logic [DATA_W-1:0] SET_WORD = {{(DATA_W-1){1'b0}}, 1'b1};

  tas_phase_e        phase_q;
  logic [DATA_W-1:0] old_q;
  logic [IDX_W-1:0]  hold_idx_q;
  logic              tas_start, store_go;

  assign hold_o     = (phase_q == PH_HOLD);
  assign hold_idx_o = hold_idx_q;
  assign want_o     = valid_i & hit_i & ~hold_o;
  assign tas_start  = grant_i & ~write_i;
  assign store_go   = grant_i & write_i;

  // A test-and-set stores the one on its first edge; the port then owns the word.
  assign we_o      = grant_i;
  assign we_data_o = write_i ? wdata_i : SET_WORD;

  assign ready_o     = hit_i ? (hold_o | store_go) : mem_ready_i;
  assign rdata_o     = hit_i ? old_q : mem_rdata_i;
  assign stall_o     = valid_i & ~ready_o;
  assign mem_valid_o = valid_i & ~hit_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      old_q      <= '0;
      hold_idx_q <= '0;
    end else if (tas_start) begin
      phase_q    <= PH_HOLD;
      old_q      <= lock_rd_i;
      hold_idx_q <= idx_i;
    end else if (hold_o && valid_i) begin
      phase_q <= PH_IDLE;
    end
  end

  // R2: the cycle that starts a test-and-set never completes it.
  assert_first_cycle_stalls_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tas_start |-> !ready_o);

  // R2: a held test-and-set finishes on the following edge.
  assert_hold_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && valid_i) |=> !hold_o);
endmodule

// File: rtl/tas_arbiter.sv
module tas_arbiter
  import tas_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS-1:0]           want_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] idx_i,
  input  logic [NUM_PORTS-1:0]           hold_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] hold_idx_i,
  output logic [NUM_PORTS-1:0]           grant_o
);
  logic blocked0, blocked1, same_word;

  // A word owned by the other port's test-and-set is off limits.
  assign blocked0  = hold_i[1] && (hold_idx_i[1] == idx_i[0]);
  assign blocked1  = hold_i[0] && (hold_idx_i[0] == idx_i[1]);
  assign same_word = (idx_i[0] == idx_i[1]);

  // Port 0 has fixed priority on a same-cycle clash.
  assign grant_o[0] = want_i[0] & ~blocked0;
  assign grant_o[1] = want_i[1] & ~blocked1 & ~(grant_o[0] & same_word);

  // R7: the two ports never hold the same word at once.
  assert_single_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_i[0] && hold_i[1] && (hold_idx_i[0] == hold_idx_i[1])));
endmodule

// File: rtl/tas_lock_store.sv
module tas_lock_store
  import tas_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LOCKS  = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PORTS-1:0]            we_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]  idx_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] locks [LOCKS];

  for (genvar i = 0; i < LOCKS; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        locks[i] <= '0;
      end else if (we_i[0] && (idx_i[0] == IDX_W'(i))) begin
        locks[i] <= wdata_i[0];
      end else if (we_i[1] && (idx_i[1] == IDX_W'(i))) begin
        locks[i] <= wdata_i[1];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assign rdata_o[p] = locks[idx_i[p]];
  end

  logic              last_we_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic [DATA_W-1:0] last_data_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      last_we_q   <= 1'b0;
      last_idx_q  <= '0;
      last_data_q <= '0;
    end else begin
      last_we_q   <= we_i[0] | we_i[1];
      last_idx_q  <= we_i[0] ? idx_i[0] : idx_i[1];
      last_data_q <= we_i[0] ? wdata_i[0] : wdata_i[1];
    end
  end

  // R6: arbitration never lets both ports write one word in a cycle.
  assert_no_double_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i[0] && we_i[1] && (idx_i[0] == idx_i[1])));

  // R5: a granted write is visible in the word on the next cycle.
  assert_write_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_we_q |-> (locks[last_idx_q] == last_data_q));
endmodule

// File: rtl/tas_sync_bank.sv
module tas_sync_bank
  import tas_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LOCKS  = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_FFE0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             req_valid_i,
  output logic [1:0]             req_ready_o,
  input  logic [1:0]             req_write_i,
  input  logic [1:0][ADDR_W-1:0] req_addr_i,
  input  logic [1:0][DATA_W-1:0] req_wdata_i,
  output logic [1:0][DATA_W-1:0] rsp_rdata_o,
  output logic [1:0]             stall_o,
  output logic [1:0]             mem_valid_o,
  input  logic [1:0]             mem_ready_i,
  output logic [1:0]             mem_write_o,
  output logic [1:0][ADDR_W-1:0] mem_addr_o,
  output logic [1:0][DATA_W-1:0] mem_wdata_o,
  input  logic [1:0][DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(LOCKS);

  logic [NUM_PORTS-1:0]             hit, want, hold, grant, we;
  logic [NUM_PORTS-1:0][IDX_W-1:0]  idx, hold_idx;
  logic [NUM_PORTS-1:0][DATA_W-1:0] we_data, lock_rd;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tas_addr_decode #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)
    ) u_dec (
      .addr_i(req_addr_i[p]), .hit_o(hit[p]), .idx_o(idx[p])
    );

    tas_port_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .valid_i     (req_valid_i[p]),
      .write_i     (req_write_i[p]),
      .wdata_i     (req_wdata_i[p]),
      .hit_i       (hit[p]),
      .idx_i       (idx[p]),
      .grant_i     (grant[p]),
      .lock_rd_i   (lock_rd[p]),
      .mem_ready_i (mem_ready_i[p]),
      .mem_rdata_i (mem_rdata_i[p]),
      .want_o      (want[p]),
      .hold_o      (hold[p]),
      .hold_idx_o  (hold_idx[p]),
      .we_o        (we[p]),
      .we_data_o   (we_data[p]),
      .ready_o     (req_ready_o[p]),
      .rdata_o     (rsp_rdata_o[p]),
      .stall_o     (stall_o[p]),
      .mem_valid_o (mem_valid_o[p])
    );

    // R7: a word stays taken for the whole of a test-and-set.
    assert_held_word_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold[p] && req_valid_i[p]) |-> (lock_rd[p] != '0));

    // R1: forwarded traffic never coexists with a lock operation on its port.
    assert_passthrough_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_valid_o[p] |-> !hold[p]);
  end

  assign mem_write_o = req_write_i;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  tas_arbiter #(.IDX_W(IDX_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_i     (want),
    .idx_i      (idx),
    .hold_i     (hold),
    .hold_idx_i (hold_idx),
    .grant_o    (grant)
  );

  tas_lock_store #(.DATA_W(DATA_W), .LOCKS(LOCKS), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (we_data),
    .rdata_o (lock_rd)
  );
endmodule

// File: tb/tas_sync_bank_bench.sv
module tas_sync_bank_bench;
  localparam logic [31:0] WIN  = 32'hFFFF_FFE0;
  localparam logic [31:0] MKEY = 32'h5A5A_0F0F;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       req_valid = '0;
  logic [1:0]       req_ready;
  logic [1:0]       req_write = '0;
  logic [1:0][31:0] req_addr = '0;
  logic [1:0][31:0] req_wdata = '0;
  logic [1:0][31:0] rsp_rdata;
  logic [1:0]       stall;
  logic [1:0]       mem_valid;
  logic [1:0]       mem_ready = 2'b11;
  logic [1:0]       mem_write;
  logic [1:0][31:0] mem_addr;
  logic [1:0][31:0] mem_wdata;
  logic [1:0][31:0] mem_rdata;

  int checks = 0;
  int fails = 0;
  int cyc_cnt = 0;
  logic [31:0] model [16];
  logic [31:0] r0, r1;
  int c0, c1;

  always #4 clk = ~clk;

  assign mem_rdata[0] = mem_addr[0] ^ MKEY;
  assign mem_rdata[1] = mem_addr[1] ^ MKEY;

  tas_sync_bank u_tas_sync_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .stall_o(stall), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_write_o(mem_write), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(logic [31:0] a);
    return a[31:4] == WIN[31:4];
  endfunction

  // One request on port p; returns load data and the cycle count to handshake.
  task automatic op(int p, bit w, logic [31:0] a, logic [31:0] d,
                    output logic [31:0] r, output int cyc);
    @(negedge clk);
    req_valid[p] = 1'b1; req_write[p] = w; req_addr[p] = a; req_wdata[p] = d;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      check(stall[p] == !req_ready[p], "R10 stall", 32'(stall[p]), 32'(!req_ready[p]));
      if (!in_win(a)) begin
        check(mem_valid[p] && mem_addr[p] == a && mem_wdata[p] == d && mem_write[p] == w,
              "R1 forward", mem_addr[p], a);
      end
      if (req_ready[p]) begin
        r = rsp_rdata[p];
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 req_valid[p] = 1'b0;
  endtask

  // Model of a lone operation; returns the expected load data.
  function automatic logic [31:0] model_op(bit w, logic [31:0] a, logic [31:0] d);
    logic [31:0] e;
    if (!in_win(a)) return a ^ MKEY;
    e = model[a[3:0]];
    model[a[3:0]] = w ? d : 32'd1;
    return e;
  endfunction

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] e0, e1;
    void'($urandom(32'd20240426));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(stall == 2'b00 && mem_valid == 2'b00, "R8 idle", 32'(stall), 32'd0);

    // R8 / R9 / R3: each word starts unlocked and is independent.
    for (int i = 0; i < 16; i++) begin
      op(0, 1'b0, WIN | 32'(i), '0, r0, c0);
      check(r0 == 32'd0, "R8 reset word", r0, 32'd0);
      check(c0 == 2, "R2 tas cycles", 32'(c0), 32'd2);
      model[i] = 32'd1;
    end
    // R4: second test-and-set sees the one left behind.
    op(1, 1'b0, WIN | 32'd3, '0, r0, c0);
    check(r0 == 32'd1, "R4 set to one", r0, 32'd1);
    // R5: release with zero, then reacquire.
    op(1, 1'b1, WIN | 32'd3, 32'd0, r0, c0);
    check(c0 == 1, "R2 store cycles", 32'(c0), 32'd1);
    op(0, 1'b0, WIN | 32'd3, '0, r0, c0);
    check(r0 == 32'd0, "R5 release", r0, 32'd0);
    // R3: arbitrary old value comes back, then word is 1.
    op(0, 1'b1, WIN | 32'd15, 32'hDEAD_BEEF, r0, c0);
    op(1, 1'b0, WIN | 32'd15, '0, r0, c0);
    check(r0 == 32'hDEAD_BEEF, "R3 old value", r0, 32'hDEAD_BEEF);
    op(1, 1'b0, WIN | 32'd15, '0, r0, c0);
    check(r0 == 32'd1, "R4 after value", r0, 32'd1);

    // R1: window edges are ordinary memory.
    op(0, 1'b0, 32'hFFFF_FFDF, '0, r0, c0);
    check(r0 == (32'hFFFF_FFDF ^ MKEY) && c0 == 1, "R1 below window", r0, 32'hFFFF_FFDF ^ MKEY);
    op(1, 1'b0, 32'hFFFF_FFF0, '0, r0, c0);
    check(r0 == (32'hFFFF_FFF0 ^ MKEY) && c0 == 1, "R1 above window", r0, 32'hFFFF_FFF0 ^ MKEY);
    op(1, 1'b1, 32'h0000_1234, 32'h55, r0, c0);
    check(c0 == 1, "R1 store no stall", 32'(c0), 32'd1);
    mem_ready[0] = 1'b0;
    fork
      op(0, 1'b0, 32'h0000_1000, '0, r0, c0);
      begin repeat (2) @(posedge clk); #2 mem_ready[0] = 1'b1; end
    join
    check(c0 == 3, "R1 follows mem_ready", 32'(c0), 32'd3);

    // R6: same-cycle clash on an unlocked word.
    for (int i = 0; i < 16; i++) model[i] = 32'd1;
    op(0, 1'b1, WIN | 32'd5, 32'd0, r0, c0);
    model[5] = 32'd0;
    fork
      op(0, 1'b0, WIN | 32'd5, '0, r0, c0);
      op(1, 1'b0, WIN | 32'd5, '0, r1, c1);
    join
    check(r0 == 32'd0, "R6 port0 wins", r0, 32'd0);
    check(r1 == 32'd1, "R6 port1 sees taken", r1, 32'd1);
    check(c1 == 4, "R6 port1 stalled", 32'(c1), 32'd4);
    // R6: clashing stores, port 1 lands last.
    fork
      op(0, 1'b1, WIN | 32'd6, 32'hAAAA, r0, c0);
      op(1, 1'b1, WIN | 32'd6, 32'hBBBB, r1, c1);
    join
    check(c0 == 1 && c1 == 2, "R6 store order cycles", 32'(c1), 32'd2);
    op(0, 1'b0, WIN | 32'd6, '0, r0, c0);
    check(r0 == 32'hBBBB, "R6 store order value", r0, 32'hBBBB);

    // R7: late store during the other port's test-and-set.
    op(1, 1'b1, WIN | 32'd9, 32'd0, r0, c0);
    fork
      op(1, 1'b0, WIN | 32'd9, '0, r1, c1);
      begin @(negedge clk); op(0, 1'b1, WIN | 32'd9, 32'h77, r0, c0); end
    join
    check(r1 == 32'd0 && c1 == 2, "R7 owner result", r1, 32'd0);
    check(c0 == 2, "R7 late store stalled", 32'(c0), 32'd2);
    op(0, 1'b0, WIN | 32'd9, '0, r0, c0);
    check(r0 == 32'h77, "R7 store after tas", r0, 32'h77);
    // R7: late load during the other port's test-and-set.
    op(0, 1'b1, WIN | 32'd10, 32'd0, r0, c0);
    fork
      op(0, 1'b0, WIN | 32'd10, '0, r0, c0);
      begin @(negedge clk); op(1, 1'b0, WIN | 32'd10, '0, r1, c1); end
    join
    check(r1 == 32'd1 && c1 == 3, "R7 late load", r1, 32'd1);

    // R9: different words in the same cycle proceed together.
    fork
      op(0, 1'b0, WIN | 32'd1, '0, r0, c0);
      op(1, 1'b0, WIN | 32'd2, '0, r1, c1);
    join
    check(c0 == 2 && c1 == 2, "R9 parallel", 32'(c1), 32'd2);

    // Random mix, resynchronise model.
    for (int i = 0; i < 16; i++) begin
      op(0, 1'b1, WIN | 32'(i), 32'(i * 3), r0, c0);
      model[i] = 32'(i * 3);
    end
    for (int it = 0; it < 400; it++) begin
      int kind = $urandom_range(0, 2);
      bit w0 = $urandom_range(0, 1) == 1;
      bit w1 = $urandom_range(0, 1) == 1;
      logic [31:0] a0 = WIN | ($urandom() & 32'hF);
      logic [31:0] a1 = WIN | ($urandom() & 32'hF);
      logic [31:0] d0 = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom();
      logic [31:0] d1 = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom();
      if (kind == 0) begin
        int p = $urandom_range(0, 1);
        if ($urandom_range(0, 2) == 0) a0 = $urandom() & 32'h7FFF_FFFF;
        e0 = model_op(w0, a0, d0);
        op(p, w0, a0, d0, r0, c0);
        if (!w0) check(r0 == e0, "R3 random single", r0, e0);
        check(c0 == ((in_win(a0) && !w0) ? 2 : 1), "R2 random cycles", 32'(c0), 32'd0);
      end else begin
        e0 = model_op(w0, a0, d0);
        e1 = model_op(w1, a1, d1);
        fork
          op(0, w0, a0, d0, r0, c0);
          op(1, w1, a1, d1, r1, c1);
        join
        if (!w0) check(r0 == e0, "R6 random port0", r0, e0);
        if (!w1) check(r1 == e1, "R6 random port1", r1, e1);
        if (a0 != a1)
          check(c1 == (w1 ? 1 : 2), "R9 random parallel", 32'(c1), 32'(w1 ? 1 : 2));
        else
          check(c1 == (w0 ? 1 : 2) + (w1 ? 1 : 2), "R6 random stall", 32'(c1), 32'd0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule